// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two up-counting channels. Each channel keeps a low count byte and a high count byte. A per-channel mode field joins the two bytes into a 13-bit counter or a 16-bit counter. It can also make an 8-bit counter that reloads itself from the high byte, or, on channel 0 only, two independent 8-bit counters. Each channel is stepped by one of two sources. The first is a shared divide-by-12 prescaler on the system clock. The second is the falling edges seen on that channel's event pin, after a two-flop synchroniser.

Software programs the block through a small write/read register port. That port covers a configuration byte, a control byte holding run bits and overflow flags, and the four count bytes. Counting is allowed by the channel's run bit. If the channel's gate option is set, its gate pin must also be high. Every overflow sets a sticky flag, and the two flags drive the two interrupt-request outputs directly.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset every register reads 0x00, both channels are stopped and both interrupt outputs are low.
- R2: Register addresses are 0 configuration, 1 control, 2 channel-0 low, 3 channel-0 high, 4 channel-1 low, 5 channel-1 high. All six read back what was written. Configuration bits [7:4] set channel 1 and bits [3:0] set channel 0, each nibble ordered gate option, event select, mode[1:0]. Control bit 7 is flag 1, bit 6 run 1, bit 5 flag 0 and bit 4 run 0. Control bits [3:0] are stored and have no effect.
- R3: With event select 0, a running channel advances exactly once per 12 system clocks.
- R4: With event select 1, a running channel advances once for each 1-to-0 transition on its event pin, and not on 0-to-1 transitions.
- R5: A channel counts only while its run bit is 1 and, when its gate option is 1, only while its gate pin is also high.
- R6: Mode 0 counts {high, low[4:0]} as 13 bits and leaves low[7:5] untouched. The 0x1FFF-to-0 rollover sets the flag.
- R7: Mode 1 counts {high, low} as 16 bits. The 0xFFFF-to-0 rollover sets the flag.
- R8: Mode 2 counts in the low byte. On the 0xFF step it loads the high byte into the low byte and sets the flag, and the high byte is unchanged.
- R9: Mode 3 on channel 0 splits it into two 8-bit counters. The low byte uses channel 0's source, gating and run bit and sets flag 0. The high byte steps on the prescaler when run 1 is set, and sets flag 1. In that state channel 1 overflows set no flag. Channel 1 in mode 3 holds its count.
- R10: A flag stays set until a control write clears it. Interrupt output i equals flag i.
- R11: A count-byte write in the same cycle as a hardware step wins, and the step and its overflow are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data (combinational) |
| ev_in | input | 2 | Event pins, bit i for channel i |
| gate_in | input | 2 | Gate pins, bit i for channel i |
| irq | output | 2 | Interrupt requests, bit i is flag i |

## Verification
The assertions check on every cycle the following. The prescaler stays in range and never ticks on two cycles in a row. A detected falling edge lasts one cycle. The reload follows the high byte. Low[7:5] is kept in mode 0. A stopped channel keeps its count. A written byte takes the written value. Flags set on overflow and stay set. Channel 1 in mode 3 holds its count. The bench scenarios show the rest. These are the exact counts across each mode's rollover, the twelve-clock rate over a long window, and gating by the pin. They also show the split-mode flag routing and the exact cycle at which a write collides with an edge.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate_opt;
    logic   ev_sel;
    tmode_e mode;
  } chan_cfg_t;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              wrap;
  } step_t;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_LO0  = 3'd2;
  localparam logic [2:0] A_HI0  = 3'd3;
  localparam logic [2:0] A_LO1  = 3'd4;
  localparam logic [2:0] A_HI1  = 3'd5;

  // Control byte positions
  localparam int C_RUN0  = 4;
  localparam int C_FLAG0 = 5;
  localparam int C_RUN1  = 6;
  localparam int C_FLAG1 = 7;

  // One counting step for the main counter of a channel in a given mode.
  function automatic step_t step_count(tmode_e m, logic [BYTE_W-1:0] lo,
                                       logic [BYTE_W-1:0] hi);
    step_t r;
    logic [12:0] c13;
    logic [15:0] c16;
    r = '{lo: lo, hi: hi, wrap: 1'b0};
    c13 = '0;
    c16 = '0;
    case (m)
      MODE_13: begin
        c13    = {hi, lo[4:0]} + 13'd1;
        r.lo   = {lo[7:5], c13[4:0]};
        r.hi   = c13[12:5];
        r.wrap = &{hi, lo[4:0]};
      end
      MODE_16: begin
        c16    = {hi, lo} + 16'd1;
        r.lo   = c16[7:0];
        r.hi   = c16[15:8];
        r.wrap = &{hi, lo};
      end
      MODE_RELOAD: begin
        r.wrap = &lo;
        r.lo   = (&lo) ? hi : lo + 8'd1;
      end
      default: begin
        r.wrap = &lo;
        r.lo   = lo + 8'd1;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dtu_prescale.sv
module dtu_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  assign tick = (cnt_q == LAST);

  p_prescale_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dtu_fall_detect.sv
module dtu_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  // older sample high, newer sample low
  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

  p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dtu_channel.sv
module dtu_channel
  import dtu_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              step_lo,
  input  logic              step_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              wrap_lo,
  output logic              wrap_hi
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  step_t nxt;
  logic  split, hold, go_main, go_hi;

  generate
    if (SPLIT_OK) begin : g_split
      assign split = (mode == MODE_SPLIT);
      assign hold  = 1'b0;
      assign go_hi = split & step_hi & ~wr_hi;
    end else begin : g_nosplit
      assign split = 1'b0;
      assign hold  = (mode == MODE_SPLIT);
      assign go_hi = 1'b0;
    end
  endgenerate

  assign nxt     = step_count(mode, lo_q, hi_q);
  assign go_main = step_lo & ~hold & ~wr_lo & (split | ~wr_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo)        lo_q <= wdata;
      else if (go_main) lo_q <= nxt.lo;
      if (wr_hi)                   hi_q <= wdata;
      else if (go_hi)              hi_q <= hi_q + 8'd1;
      else if (go_main && !split)  hi_q <= nxt.hi;
    end
  end

  assign lo      = lo_q;
  assign hi      = hi_q;
  assign wrap_lo = go_main & nxt.wrap;
  assign wrap_hi = go_hi & (&hi_q);

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_lo && !wr_lo && !wr_hi && mode == MODE_RELOAD && lo_q == 8'hFF)
      |=> (lo_q == $past(hi_q)));
  p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_13 && !wr_lo) |=> (lo_q[7:5] == $past(lo_q[7:5])));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_lo && !step_hi && !wr_lo && !wr_hi) |=> $stable({hi_q, lo_q}));
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));
  p_t1_split_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!SPLIT_OK && mode == MODE_SPLIT && !wr_lo && !wr_hi) |=> $stable({hi_q, lo_q}));
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int NCH         = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic [1:0]  ev_in,
  input  logic [1:0]  gate_in,
  output logic [1:0]  irq
);
  logic [BYTE_W-1:0] cfg_q, ctrl_q;
  logic              tick;
  logic [NCH-1:0]    fall, run, adv, tr, tf;
  logic [NCH-1:0]    wrap_lo, wrap_hi, wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo [NCH];
  logic [BYTE_W-1:0] hi [NCH];
  chan_cfg_t         cfg [NCH];
  logic              ctrl_wr, split0, set_tf0, set_tf1;

  dtu_prescale #(.DIV(PRESCALE)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign tr = {ctrl_q[C_RUN1], ctrl_q[C_RUN0]};
  assign tf = {ctrl_q[C_FLAG1], ctrl_q[C_FLAG0]};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      dtu_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(ev_in[i]), .fall(fall[i]));
      assign cfg[i]   = chan_cfg_t'(cfg_q[4*i +: 4]);
      assign run[i]   = tr[i] & (~cfg[i].gate_opt | gate_in[i]);
      assign adv[i]   = run[i] & (cfg[i].ev_sel ? fall[i] : tick);
      assign wr_lo[i] = wr_en && (wr_addr == A_LO0 + 3'(2*i));
      assign wr_hi[i] = wr_en && (wr_addr == A_HI0 + 3'(2*i));
      dtu_channel #(.SPLIT_OK(i == 0)) u_chan (
        .clk(clk), .rst_n(rst_n), .mode(cfg[i].mode),
        .step_lo(adv[i]), .step_hi((i == 0) ? (tick & tr[1]) : 1'b0),
        .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(wr_data),
        .lo(lo[i]), .hi(hi[i]), .wrap_lo(wrap_lo[i]), .wrap_hi(wrap_hi[i]));
    end
  endgenerate

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign split0  = (cfg[0].mode == MODE_SPLIT);
  assign set_tf0 = wrap_lo[0];
  assign set_tf1 = split0 ? wrap_hi[0] : (wrap_lo[1] | wrap_hi[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_CFG) cfg_q <= wr_data;
      if (ctrl_wr) ctrl_q <= wr_data;
      else begin
        if (set_tf0) ctrl_q[C_FLAG0] <= 1'b1;
        if (set_tf1) ctrl_q[C_FLAG1] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG:   rd_data = cfg_q;
      A_CTRL:  rd_data = ctrl_q;
      A_LO0:   rd_data = lo[0];
      A_HI0:   rd_data = hi[0];
      A_LO1:   rd_data = lo[1];
      A_HI1:   rd_data = hi[1];
      default: rd_data = '0;
    endcase
  end

  assign irq = tf;

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_tf0 && !ctrl_wr) |=> irq[0]);
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[1] && !ctrl_wr) |=> irq[1]);
  p_split_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && !wrap_hi[0] && !ctrl_wr && !irq[1]) |=> !irq[1]);
  p_run_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tr[0] && !split0 && !wr_lo[0] && !wr_hi[0]) |=> $stable({hi[0], lo[0]}));
endmodule

// File: tb/dual_timer_unit_tb.sv
module dual_timer_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] ev_in = 2'b11;
  logic [1:0] gate_in = 2'b00;
  logic [1:0] irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_timer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_in(ev_in), .gate_in(gate_in), .irq(irq));

  task automatic check(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(int ch);
    ev_in[ch] = 1'b0;
    repeat (4) @(negedge clk);
    ev_in[ch] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 reset value", v, 0);
    end
    check("R1 irq", irq, 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(3'd0, 8'hA0); rd(3'd0, v); check("R2 config", v, 8'hA0);
    wr(3'd1, 8'h0F); rd(3'd1, v); check("R2 control low nibble", v, 8'h0F);
    wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h44);
    repeat (30) @(negedge clk);
    rd(3'd2, v); check("R2 low0 no effect of ctrl[3:0]", v, 8'h11);
    rd(3'd3, v); check("R2 high0", v, 8'h22);
    rd(3'd4, v); check("R2 low1", v, 8'h33);
    rd(3'd5, v); check("R2 high1", v, 8'h44);
    check("R2 irq quiet", irq, 0);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
  endtask

  task automatic t_mode1_events;
    logic [7:0] v;
    wr(3'd0, 8'h05); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    pulse(0);
    rd(3'd2, v); check("R7 low after step", v, 8'hFF);
    check("R7 no flag yet", irq[0], 0);
    pulse(0);
    rd(3'd2, v); check("R7 low wraps", v, 8'h00);
    rd(3'd3, v); check("R7 high wraps", v, 8'h00);
    check("R7 flag set", irq[0], 1);
    ev_in[0] = 1'b0; repeat (5) @(negedge clk);
    rd(3'd2, v); check("R4 falling edge counts", v, 8'h01);
    ev_in[0] = 1'b1; repeat (5) @(negedge clk);
    rd(3'd2, v); check("R4 rising edge ignored", v, 8'h01);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_mode0;
    logic [7:0] v;
    wr(3'd0, 8'h04); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    pulse(0);
    rd(3'd2, v); check("R6 low step", v, 8'hFF);
    check("R6 no flag", irq[0], 0);
    pulse(0);
    rd(3'd2, v); check("R6 upper bits kept, low5 wrap", v, 8'hE0);
    rd(3'd3, v); check("R6 high wraps", v, 8'h00);
    check("R6 flag", irq[0], 1);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_mode2;
    logic [7:0] v;
    wr(3'd0, 8'h06); wr(3'd3, 8'h80); wr(3'd2, 8'hFF); wr(3'd1, 8'h10);
    pulse(0);
    rd(3'd2, v); check("R8 reload", v, 8'h80);
    rd(3'd3, v); check("R8 high unchanged", v, 8'h80);
    check("R8 flag", irq[0], 1);
    pulse(0);
    rd(3'd2, v); check("R8 continues", v, 8'h81);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    wr(3'd0, 8'h0D); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h10);
    gate_in[0] = 1'b0;
    pulse(0);
    rd(3'd2, v); check("R5 gate low blocks", v, 8'h00);
    gate_in[0] = 1'b1;
    pulse(0);
    rd(3'd2, v); check("R5 gate high counts", v, 8'h01);
    wr(3'd1, 8'h00);
    pulse(0);
    rd(3'd2, v); check("R5 run off holds", v, 8'h01);
    gate_in[0] = 1'b0;
  endtask

  task automatic t_internal;
    logic [7:0] a, b;
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h10);
    repeat (3) @(negedge clk);
    rd(3'd2, a);
    repeat (120) @(negedge clk);
    rd(3'd2, b);
    check("R3 ten steps in 120 clocks", int'(b - a), 10);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_split;
    logic [7:0] v, w;
    wr(3'd0, 8'h53);
    wr(3'd2, 8'hFA); wr(3'd3, 8'hFA); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h50);
    pulse(1);
    rd(3'd4, v); check("R9 channel1 still counts", v, 8'h00);
    check("R9 channel1 overflow sets no flag", irq[1], 0);
    repeat (120) @(negedge clk);
    rd(3'd2, v); rd(3'd3, w);
    check("R9 split halves step together", v, w);
    check("R9 split low wrapped", int'(v < 8'h08), 1);
    check("R9 low half sets flag0", irq[0], 1);
    check("R9 high half sets flag1", irq[1], 1);
    wr(3'd0, 8'h73); wr(3'd4, 8'h12);
    pulse(1);
    rd(3'd4, v); check("R9 channel1 mode3 holds", v, 8'h12);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
  endtask

  task automatic t_sticky;
    logic [7:0] v;
    wr(3'd0, 8'h05); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    pulse(0);
    repeat (50) @(negedge clk);
    check("R10 flag sticky", irq[0], 1);
    rd(3'd1, v); check("R10 flag in control bit5", v, 8'h30);
    wr(3'd1, 8'h10);
    check("R10 write clears flag", irq[0], 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] v;
    wr(3'd0, 8'h05); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    ev_in[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    wr(3'd2, 8'h33);
    ev_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd2, v); check("R11 write beats step low", v, 8'h33);
    rd(3'd3, v); check("R11 high untouched", v, 8'hFF);
    check("R11 overflow dropped", irq[0], 0);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mode1_events();
    t_mode0();
    t_mode2();
    t_gate();
    t_internal();
    t_split();
    t_sticky();
    t_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule